// File: doc/BRIEF.md
# Work-Group Batch Distributor

This block spreads the work-groups of one compute job over a fixed set of identical shader cores. A job is defined by two numbers: the total number of work-groups and a batch size chosen by the driver for that job. The work-group index space is linear, starting at zero. The distributor cuts it into runs of consecutive indices, called batches, and presents each batch to one core as a descriptor that holds a start index and a count. Each core has its own valid/ready port.

Batches go out in strict rotation. Batch k goes to core k modulo the number of cores, starting with core 0. If the core whose turn it is does not accept its batch, the distributor waits for that core and does not move on to another one, so the mapping of batches to cores is always the same for a given job. When the last work-group has been accepted, `done` rises. It stays high until the next job is started.

Top module: `wg_batch_dist`

## Requirements
- R1: While `rstN` is low, and after it is released, `busy` and `done` are 0 and no bit of `coreValid` is set.
- R2: A one-cycle `start` while not busy captures `totalCount` and `batchSize`. From the next cycle on, the first batch is offered to core 0 with start index 0.
- R3: Each batch's start index equals the previous batch's start index plus the previous batch's count. Together the batches cover indices 0 to total-1 exactly once.
- R4: Each batch count is the smaller of the effective batch size and the number of work-groups not yet issued. The final batch is shortened so that it never runs past the total.
- R5: A captured batch size of 0 is handled as a batch size of 1.
- R6: Batch k is offered on core (k mod NUM_CORES). While the offered core holds `coreReady` low, the same core keeps `coreValid` high and the descriptor does not change. No other core is served in the meantime.
- R7: At most one bit of `coreValid` is set in any cycle. A batch is issued in a cycle where the set bit meets the matching `coreReady` bit.
- R8: In the cycle after the final batch is accepted, `busy` is 0 and `done` is 1. `done` stays 1 with no valid raised until the next `start`.
- R9: While `busy` is 1, `start` and any change on `totalCount` or `batchSize` have no effect on the batches issued. This includes a `start` that arrives in the same cycle as the final handshake.
- R10: A job with a total of 0 issues no batch. `done` goes to 1 in the cycle after `start`.
- R11: A `start` while `done` is 1 clears `done` and begins the new job at index 0 on core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a job |
| totalCount | input | IDX_W | Number of work-groups in the job |
| batchSize | input | IDX_W | Work-groups per batch as set by the driver (0 is handled as 1) |
| busy | output | 1 | A job is being dispatched |
| done | output | 1 | Every work-group of the last job has been issued |
| coreReady | input | NUM_CORES | Per-core acceptance of the offered batch |
| coreValid | output | NUM_CORES | Per-core batch offer, at most one bit set |
| coreStart | output | NUM_CORES*IDX_W | Per-core batch start index, core i at bits [i*IDX_W +: IDX_W] |
| coreCount | output | NUM_CORES*IDX_W | Per-core batch count, core i at bits [i*IDX_W +: IDX_W] |

## Verification
Two events can fall in the same cycle: the acceptance of the final batch and a new `start` pulse. The bench drives `start` with different job values in exactly the cycle where the chosen core takes the last batch. It then expects `done` to rise with no new offer, which shows that the pulse was dropped because the block was still busy. A second `start` in the later done state must then begin a fresh job at index 0 on core 0. Random per-cycle `coreReady` patterns put handshakes next to stalls. A reference model in the bench predicts, every cycle, which core is offered and which descriptor it carries.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic load;     // capture job parameters and rewind index/core
    logic advance;  // current batch was accepted, step index and core
  } wgdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } wgdState_t;

endpackage

// File: rtl/wgd_datapath.sv
module wgd_datapath
  import wgd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 16,
  localparam int SEL_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wgdStrobe_t       strobe,
  input  logic [IDX_W-1:0] totalIn,
  input  logic [IDX_W-1:0] sizeIn,
  output logic [IDX_W-1:0] curStart,
  output logic [IDX_W-1:0] curCount,
  output logic [SEL_W-1:0] coreSel,
  output logic             lastBatch,
  output logic             zeroTotal
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_CORES - 1);

  logic [IDX_W-1:0] totalReg;
  logic [IDX_W-1:0] sizeReg;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] remaining;
  logic [IDX_W-1:0] effSize;
  logic [SEL_W-1:0] selNext;

  // size 0 is promoted to 1 at capture
  always_comb effSize = (sizeIn == '0) ? IDX_W'(1) : sizeIn;

  always_comb begin
    remaining = totalReg - nextIdx;
    lastBatch = (remaining <= sizeReg);
    curCount  = lastBatch ? remaining : sizeReg;
    curStart  = nextIdx;
  end

  always_comb zeroTotal = (totalIn == '0);

  // wrap the rotation pointer at the core count
  always_comb selNext = (coreSel == LAST_SEL) ? '0 : coreSel + SEL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalReg <= '0;
      sizeReg  <= IDX_W'(1);
      nextIdx  <= '0;
      coreSel  <= '0;
    end else if (strobe.load) begin
      totalReg <= totalIn;
      sizeReg  <= effSize;
      nextIdx  <= '0;
      coreSel  <= '0;
    end else if (strobe.advance) begin
      nextIdx  <= nextIdx + curCount;
      coreSel  <= selNext;
    end
  end

endmodule

// File: rtl/wgd_control.sv
module wgd_control
  import wgd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       zeroTotal,
  input  logic       fire,
  input  logic       lastBatch,
  output wgdStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  wgdState_t state;
  wgdState_t stateNext;

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = zeroTotal ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        // start is ignored here on purpose
        if (fire) begin
          strobe.advance = 1'b1;
          if (lastBatch) stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    busy = (state == ST_ISSUE);
    done = (state == ST_DONE);
  end

endmodule

// File: rtl/wg_batch_dist.sv
module wg_batch_dist
  import wgd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [IDX_W-1:0]           totalCount,
  input  logic [IDX_W-1:0]           batchSize,
  output logic                       busy,
  output logic                       done,
  input  logic [NUM_CORES-1:0]       coreReady,
  output logic [NUM_CORES-1:0]       coreValid,
  output logic [NUM_CORES*IDX_W-1:0] coreStart,
  output logic [NUM_CORES*IDX_W-1:0] coreCount
);

  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  wgdStrobe_t       strobe;
  logic [IDX_W-1:0] curStart;
  logic [IDX_W-1:0] curCount;
  logic [SEL_W-1:0] coreSel;
  logic             lastBatch;
  logic             zeroTotal;
  logic             fire;

  wgd_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .zeroTotal(zeroTotal),
    .fire     (fire),
    .lastBatch(lastBatch),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  wgd_datapath #(
    .NUM_CORES(NUM_CORES),
    .IDX_W    (IDX_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .totalIn  (totalCount),
    .sizeIn   (batchSize),
    .curStart (curStart),
    .curCount (curCount),
    .coreSel  (coreSel),
    .lastBatch(lastBatch),
    .zeroTotal(zeroTotal)
  );

  // per-core port fan-out
  for (genvar i = 0; i < NUM_CORES; i++) begin : gCore
    assign coreValid[i]                  = busy && (coreSel == SEL_W'(i));
    assign coreStart[i*IDX_W +: IDX_W]   = curStart;
    assign coreCount[i*IDX_W +: IDX_W]   = curCount;
  end

  assign fire = |(coreValid & coreReady);

endmodule

// File: rtl/wgd_checker.sv
module wgd_checker #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic [NUM_CORES-1:0]       coreReady,
  input logic [NUM_CORES-1:0]       coreValid,
  input logic [NUM_CORES*IDX_W-1:0] coreStart,
  input logic [NUM_CORES*IDX_W-1:0] coreCount
);

  logic             anyFire;
  logic             anyStall;
  logic             zeroCnt;
  logic [IDX_W-1:0] selStart;
  logic [IDX_W-1:0] selCount;
  logic [NUM_CORES-1:0] rotValid;

  always_comb begin
    selStart = '0;
    selCount = '0;
    zeroCnt  = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (coreValid[i]) begin
        selStart = selStart | coreStart[i*IDX_W +: IDX_W];
        selCount = selCount | coreCount[i*IDX_W +: IDX_W];
        if (coreCount[i*IDX_W +: IDX_W] == '0) zeroCnt = 1'b1;
      end
    end
    for (int i = 0; i < NUM_CORES; i++)
      rotValid[(i + 1) % NUM_CORES] = coreValid[i];
    anyFire  = |(coreValid & coreReady);
    anyStall = |(coreValid & ~coreReady);
  end

  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coreValid)); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (coreValid == '0) && !busy); // R8

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    anyStall |=> (coreValid == $past(coreValid)) && (selStart == $past(selStart))
                 && (selCount == $past(selCount))); // R6

  AST_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    anyFire |=> (coreValid == '0) || (coreValid == $past(rotValid))); // R6

  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rstN)
    anyFire |=> (coreValid == '0) || (selStart == $past(selStart + selCount))); // R3

  AST_NONZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !zeroCnt); // R5

  AST_FIRST_ON_CORE0: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (coreValid == '0) || (coreValid[0] && selStart == '0)); // R2

endmodule

bind wg_batch_dist wgd_checker #(
  .NUM_CORES(NUM_CORES),
  .IDX_W    (IDX_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .coreReady(coreReady),
  .coreValid(coreValid),
  .coreStart(coreStart),
  .coreCount(coreCount)
);

// File: tb/wg_batch_dist_test.sv
module wg_batch_dist_test;

  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rstN;
  logic           start;
  logic [W-1:0]   totalCount;
  logic [W-1:0]   batchSize;
  logic           busy;
  logic           done;
  logic [N-1:0]   coreReady;
  logic [N-1:0]   coreValid;
  logic [N*W-1:0] coreStart;
  logic [N*W-1:0] coreCount;

  always #10 clk = ~clk;  // 50 MHz

  wg_batch_dist #(.NUM_CORES(N), .IDX_W(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .totalCount(totalCount),
    .batchSize(batchSize), .busy(busy), .done(done), .coreReady(coreReady),
    .coreValid(coreValid), .coreStart(coreStart), .coreCount(coreCount)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "init";

  // reference model state
  int  mTotal, mSize, mIdx, mCore;
  bit  mBusy, mDone, mZeroSize;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  function automatic int expCount();
    int rem = mTotal - mIdx;
    return (rem < mSize) ? rem : mSize;
  endfunction

  // one cycle: check outputs at negedge, drive new inputs, advance model
  task automatic step(input bit doStart, input int t, input int s, input int prob,
                      input bit startOnLast);
    bit fireNow, lastNow;
    @(negedge clk);
    chk(busy == mBusy, "R8", int'(busy), int'(mBusy));
    chk(done == mDone, mTotal == 0 ? "R10" : "R8", int'(done), int'(mDone));
    if (mBusy) begin
      chk(coreValid == N'(1 << mCore), "R6", int'(coreValid), 1 << mCore);
      chk(int'(coreStart[mCore*W +: W]) == mIdx, mIdx == 0 ? "R2" : "R3",
          int'(coreStart[mCore*W +: W]), mIdx);
      chk(int'(coreCount[mCore*W +: W]) == expCount(), mZeroSize ? "R5" : "R4",
          int'(coreCount[mCore*W +: W]), expCount());
    end else begin
      chk(coreValid == '0, "R7", int'(coreValid), 0);
    end
    for (int i = 0; i < N; i++) coreReady[i] = ($urandom_range(0, 99) < prob);
    start      = doStart;
    totalCount = W'(t);
    batchSize  = W'(s);
    fireNow = mBusy && coreReady[mCore];
    lastNow = fireNow && (mIdx + expCount() == mTotal);
    if (startOnLast && lastNow) begin
      start      = 1'b1;
      totalCount = W'(t + 7);
      batchSize  = W'(s + 1);
    end
    if (mBusy) begin
      if (fireNow) begin
        mIdx  = mIdx + expCount();
        mCore = (mCore + 1) % N;
        if (mIdx == mTotal) begin mBusy = 0; mDone = 1; end
      end
    end else if (start) begin
      mTotal    = t;
      mZeroSize = (s == 0);
      mSize     = (s == 0) ? 1 : s;
      mIdx      = 0;
      mCore     = 0;
      mBusy     = (t != 0);
      mDone     = (t == 0);
    end
  endtask

  // mode 0 plain, 1 start mid-job, 2 start on final handshake
  task automatic runJob(input int t, input int s, input int prob, input int mode);
    int n = 0;
    step(1, t, s, prob, 0);
    while (mBusy && n < 3000) begin
      n++;
      if (mode == 1 && n == 2) step(1, t + 9, s + 3, prob, 0);
      else                     step(0, t + n, s + n, prob, mode == 2);
    end
    step(0, 5, 2, prob, 0);
    step(0, 3, 1, prob, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; start = 1'b0; totalCount = '0; batchSize = '0; coreReady = '0;
    mTotal = 0; mSize = 1; mIdx = 0; mCore = 0; mBusy = 0; mDone = 0; mZeroSize = 0;
    phase = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && coreValid == '0, "R1", int'(coreValid), 0);
    rstN = 1'b1;
    step(0, 0, 0, 50, 0);

    phase = "R2 R4 directed exact multiple";  runJob(12, 4, 100, 0);
    phase = "R4 short final batch";           runJob(10, 4, 60, 0);
    phase = "R5 size zero";                   runJob(6, 0, 70, 0);
    phase = "R10 empty job";                  runJob(0, 3, 80, 0);
    phase = "R6 heavy stalls";                runJob(23, 3, 15, 0);
    phase = "R9 start mid job";               runJob(17, 2, 50, 1);
    phase = "R9 start on final handshake";    runJob(9, 2, 100, 2);
    phase = "R11 restart from done";          runJob(5, 8, 90, 0);
    phase = "R4 size above total";            runJob(3, 20, 50, 0);

    for (int k = 0; k < 40; k++) begin
      phase = "R3 random";
      runJob($urandom_range(0, 45), $urandom_range(0, 9),
             $urandom_range(10, 100), $urandom_range(0, 2));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule